// File: doc/BRIEF.md
# Manchester Line Encoder with Selectable Idle

This block takes NRZ transmit data and a transmit-enable from a media access controller and turns them into a serial Manchester stream at half the reference rate. With a 20 MHz reference each bit cell spans two reference periods, giving 10 Mbit/s. The stream leaves as two digital drive legs, positive and negative, for an external differential driver. The block also produces the controller's transmit clock. Each rising edge of that clock marks the reference edge on which the next data bit and enable are taken.

When no frame is being sent, the line rests in one of two states chosen by a static select. In half-step mode both legs are low, so the differential output is zero. A frame ends with one whole cell held at the positive level before the legs drop to zero, which makes the end of the frame distinct from any data cell. In full-step mode the positive level is held for as long as the line is idle. A loopback input turns off both line legs and sends the encoded stream to a local decoder port.

Top module: `manch_tx`

## Requirements
- R1: `tx_clk_o` is high for the first half of every bit cell and low for the second half. It rises on the reference edge that starts a cell, and a cell lasts 2*HALF_LEN reference cycles (2 by default). After reset the first cell begins in its first half.
- R2: `tx_en_i` and `tx_data_i` are sampled only on the reference edge that starts a cell. A change at any other edge does not alter the cell in progress.
- R3: In a data cell with bit d, `line_p_o` carries ~d in the first half and d in the second half. `line_n_o` is the complement of `line_p_o`.
- R4: Every data cell has a transition on `line_p_o` between its first and second half.
- R5: When `tx_en_i` is low at a cell start, the cell in progress has already been sent in full. Only then does the line leave the data state.
- R6: In half-step mode (`full_step_i`=0), the cell after the last data cell drives `line_p_o`=1 and `line_n_o`=0 for the whole cell. After that cell both legs are 0.
- R7: In full-step mode (`full_step_i`=1), the idle line and the cell after the last data cell both drive `line_p_o`=1 and `line_n_o`=0.
- R8: `line_p_o` and `line_n_o` are never high at the same time.
- R9: While `loopback_i`=1, both line legs are 0. `lb_valid_o` is 1 during data cells, and `lb_data_o` carries the encoded symbol while `lb_valid_o` is 1 and is 0 otherwise. While `loopback_i`=0, both loopback outputs are 0.
- R10: While `rst_ni` is low the line is idle with no tail pending, and `tx_clk_o` is 1. The idle level follows `full_step_i` combinationally.
- R11: If `tx_en_i` is high at the start of the cell that follows the end-of-frame cell, a new data cell begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, one period per half cell |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable from the controller |
| tx_data_i | input | 1 | NRZ transmit data |
| full_step_i | input | 1 | Idle select: 0 = half-step (zero), 1 = full-step (positive level held) |
| loopback_i | input | 1 | Active high; turns off the line legs and drives the loopback port |
| tx_clk_o | output | 1 | Transmit clock to the controller; rises at each cell start |
| line_p_o | output | 1 | Positive line drive leg |
| line_n_o | output | 1 | Negative line drive leg |
| lb_data_o | output | 1 | Encoded stream for the local decoder |
| lb_valid_o | output | 1 | High during data cells while in loopback |

## Verification
A bit sampled on the reference edge that starts a cell shows up on the legs and the loopback port in the very next reference cycle, as the first-half symbol. The second-half symbol follows one cycle after that. Changes to the idle select and to loopback reach the outputs in the same cycle, with no register in the path. The bench changes inputs only on the falling edge in the second half of a cell. It checks the first-half result at the next falling edge and the second-half result at the falling edge after that, so every check lands inside the half cell it describes. Checks of the reset level are made with the clock stopped relative to reset, because the reset acts asynchronously.

// File: rtl/manch_tx_pkg.sv
package manch_tx_pkg;
  typedef enum logic [1:0] {
    LN_IDLE = 2'd0,
    LN_DATA = 2'd1,
    LN_TAIL = 2'd2
  } ln_state_e;
endpackage

// File: rtl/manch_tx_timer.sv
module manch_tx_timer #(
  parameter int HALF_LEN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic first_half_o,
  output logic mid_end_o,
  output logic cell_end_o
);
  localparam int CELL_LEN = 2 * HALF_LEN;
  localparam int CW = (CELL_LEN > 1) ? $clog2(CELL_LEN) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (cell_end_o) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign first_half_o = (cnt_q < CW'(HALF_LEN));
  assign mid_end_o    = (cnt_q == CW'(HALF_LEN - 1));
  assign cell_end_o   = (cnt_q == CW'(CELL_LEN - 1));
endmodule

// File: rtl/manch_tx_seq.sv
module manch_tx_seq
  import manch_tx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cell_end_i,
  input  logic      tx_en_i,
  input  logic      tx_data_i,
  output ln_state_e st_o,
  output logic      bit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o  <= LN_IDLE;
      bit_o <= 1'b0;
    end else if (cell_end_i) begin
      if (tx_en_i) begin
        st_o  <= LN_DATA;
        bit_o <= tx_data_i;
      end else if (st_o == LN_DATA) begin
        st_o  <= LN_TAIL;  // one marker cell before idle
      end else begin
        st_o  <= LN_IDLE;
      end
    end
  end
endmodule

// File: rtl/manch_tx_drive.sv
module manch_tx_drive
  import manch_tx_pkg::*;
(
  input  ln_state_e st_i,
  input  logic      bit_i,
  input  logic      first_half_i,
  input  logic      full_step_i,
  input  logic      loopback_i,
  output logic      line_p_o,
  output logic      line_n_o,
  output logic      lb_data_o,
  output logic      lb_valid_o
);
  logic sym;
  logic p_raw, n_raw;

  assign sym = first_half_i ? ~bit_i : bit_i;

  always_comb begin
    p_raw = 1'b0;
    n_raw = 1'b0;
    case (st_i)
      LN_DATA: begin
        p_raw = sym;
        n_raw = ~sym;
      end
      LN_TAIL: p_raw = 1'b1;
      default: p_raw = full_step_i;
    endcase
  end

  assign line_p_o   = p_raw & ~loopback_i;
  assign line_n_o   = n_raw & ~loopback_i;
  assign lb_valid_o = loopback_i & (st_i == LN_DATA);
  assign lb_data_o  = lb_valid_o & sym;
endmodule

// File: rtl/manch_tx.sv
module manch_tx
  import manch_tx_pkg::*;
#(
  parameter int HALF_LEN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic tx_data_i,
  input  logic full_step_i,
  input  logic loopback_i,
  output logic tx_clk_o,
  output logic line_p_o,
  output logic line_n_o,
  output logic lb_data_o,
  output logic lb_valid_o
);
  logic      first_half;
  logic      mid_end;
  logic      cell_end;
  ln_state_e ln_st;
  logic      cur_bit;

  manch_tx_timer #(.HALF_LEN(HALF_LEN)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .first_half_o (first_half),
    .mid_end_o    (mid_end),
    .cell_end_o   (cell_end)
  );

  manch_tx_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cell_end_i (cell_end),
    .tx_en_i    (tx_en_i),
    .tx_data_i  (tx_data_i),
    .st_o       (ln_st),
    .bit_o      (cur_bit)
  );

  manch_tx_drive u_drive (
    .st_i         (ln_st),
    .bit_i        (cur_bit),
    .first_half_i (first_half),
    .full_step_i  (full_step_i),
    .loopback_i   (loopback_i),
    .line_p_o     (line_p_o),
    .line_n_o     (line_n_o),
    .lb_data_o    (lb_data_o),
    .lb_valid_o   (lb_valid_o)
  );

  assign tx_clk_o = first_half;
endmodule

// File: rtl/manch_tx_chk.sv
module manch_tx_chk
  import manch_tx_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      tx_en_i,
  input logic      full_step_i,
  input logic      loopback_i,
  input logic      tx_clk_o,
  input logic      line_p_o,
  input logic      line_n_o,
  input logic      lb_data_o,
  input logic      lb_valid_o,
  input logic      cell_end_i,
  input logic      mid_end_i,
  input ln_state_e st_i
);
  assert_clk_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_end_i |=> $rose(tx_clk_o));

  assert_cell_atomic_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cell_end_i |=> $stable(st_i));

  assert_mid_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_end_i && st_i == LN_DATA && !loopback_i)
      |=> (loopback_i || line_p_o != $past(line_p_o)));

  assert_tail_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_end_i && st_i == LN_DATA && !tx_en_i)
      |=> (loopback_i || (line_p_o && !line_n_o)));

  assert_tail_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_end_i && st_i == LN_TAIL && !tx_en_i && !full_step_i)
      |=> (loopback_i || full_step_i || (!line_p_o && !line_n_o)));

  assert_full_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == LN_IDLE && full_step_i && !loopback_i) |-> (line_p_o && !line_n_o));

  assert_legs_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_p_o && line_n_o));

  assert_lb_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loopback_i |-> (!line_p_o && !line_n_o));

  assert_lb_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loopback_i |-> (!lb_valid_o && !lb_data_o));

  assert_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_end_i && tx_en_i) |=> (st_i == LN_DATA));
endmodule

bind manch_tx manch_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_en_i     (tx_en_i),
  .full_step_i (full_step_i),
  .loopback_i  (loopback_i),
  .tx_clk_o    (tx_clk_o),
  .line_p_o    (line_p_o),
  .line_n_o    (line_n_o),
  .lb_data_o   (lb_data_o),
  .lb_valid_o  (lb_valid_o),
  .cell_end_i  (cell_end),
  .mid_end_i   (mid_end),
  .st_i        (ln_st)
);

// File: tb/manch_tx_tb.sv
`timescale 1ns/1ps
module manch_tx_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_en_i = 1'b0, tx_data_i = 1'b0, full_step_i = 1'b0, loopback_i = 1'b0;
  logic tx_clk_o, line_p_o, line_n_o, lb_data_o, lb_valid_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  manch_tx u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_en_i     (tx_en_i),
    .tx_data_i   (tx_data_i),
    .full_step_i (full_step_i),
    .loopback_i  (loopback_i),
    .tx_clk_o    (tx_clk_o),
    .line_p_o    (line_p_o),
    .line_n_o    (line_n_o),
    .lb_data_o   (lb_data_o),
    .lb_valid_o  (lb_valid_o)
  );

  // {full_step, loopback, en, data} | first half {p,n,lbv,lbd} | second half {p,n,lbv,lbd}
  localparam int NV = 19;
  localparam logic [11:0] VEC [NV] = '{
    12'b0011_0100_1000, 12'b0010_1000_0100, 12'b0011_0100_1000, 12'b0011_0100_1000,
    12'b0000_1000_1000, 12'b0000_0000_0000, 12'b0000_0000_0000, 12'b1010_1000_0100,
    12'b1000_1000_1000, 12'b1000_1000_1000, 12'b0111_0010_0011, 12'b0110_0011_0010,
    12'b0100_0000_0000, 12'b0000_0000_0000, 12'b0010_1000_0100, 12'b0000_1000_1000,
    12'b0011_0100_1000, 12'b0000_1000_1000, 12'b0000_0000_0000
  };
  localparam string TAG [NV] = '{
    "R3", "R4", "R3", "R3", "R6", "R6", "R6", "R3", "R7", "R7",
    "R9", "R9", "R9", "R6", "R3", "R6", "R11", "R6", "R6"
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] outs();
    return {line_p_o, line_n_o, lb_valid_o, lb_data_o};
  endfunction

  task automatic to_second_half();
    @(negedge clk_i);
    while (tx_clk_o !== 1'b0) @(negedge clk_i);
  endtask

  task automatic run_all();
    // R10: reset state, asynchronous
    #12;
    chk("R10 clk", {3'b0, tx_clk_o}, 4'b0001);
    chk("R10 idle", outs(), 4'b0000);
    full_step_i = 1'b1;
    #1;
    chk("R10 R7 idle", outs(), 4'b1000);
    full_step_i = 1'b0;
    #1;
    @(negedge clk_i);
    rst_ni = 1'b1;

    to_second_half();
    for (int i = 0; i < NV; i++) begin
      {full_step_i, loopback_i, tx_en_i, tx_data_i} = VEC[i][11:8];
      @(negedge clk_i);
      chk({TAG[i], " first"}, outs(), VEC[i][7:4]);
      chk("R1 high", {3'b0, tx_clk_o}, 4'b0001);
      chk("R8", {3'b0, line_p_o & line_n_o}, 4'b0000);
      @(negedge clk_i);
      chk({TAG[i], " second"}, outs(), VEC[i][3:0]);
      chk("R1 low", {3'b0, tx_clk_o}, 4'b0000);
    end

    // R2, R5: inputs changed mid-cell do not alter or cut the cell
    {full_step_i, loopback_i, tx_en_i, tx_data_i} = 4'b0011;
    @(negedge clk_i);
    chk("R3 first", outs(), 4'b0100);
    tx_en_i = 1'b0;
    tx_data_i = 1'b0;
    @(negedge clk_i);
    chk("R2 R5 second", outs(), 4'b1000);
    @(negedge clk_i);
    chk("R5 R6 tail", outs(), 4'b1000);
    @(negedge clk_i);
    chk("R6 tail2", outs(), 4'b1000);
    @(negedge clk_i);
    chk("R6 zero", outs(), 4'b0000);

    // R10: reset taken in the middle of a data cell
    to_second_half();
    tx_en_i = 1'b1;
    tx_data_i = 1'b0;
    @(negedge clk_i);
    chk("R3 pre-reset", outs(), 4'b1000);
    rst_ni = 1'b0;
    #1;
    chk("R10 async", outs(), 4'b0000);
    chk("R10 clk async", {3'b0, tx_clk_o}, 4'b0001);
    tx_en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    fork
      run_all();
      begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule